// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block sits behind the bus of a byte-wide parallel NOR flash model. It watches host write cycles and recognises three kinds of command sequence: a reset that returns the part to plain array reads, an identification sequence that switches reads over to maker, device and protection codes, and a four-cycle byte program. Read cycles are steered to the byte array, to the identification codes, or, while a program is running, to a status byte.

The embedded program is modelled as a busy window of a fixed number of clocks. At the end of the window, the addressed byte is updated with the bitwise AND of its old value and the new data, so programming can only clear bits. During the window every write is ignored, reset included. Command addresses are compared on the low 11 address bits. The array starts fully erased (all bytes 0xFF). Read data comes out two clocks after the read strobe and is held until the next read result arrives. Reads and writes are never issued in the same cycle.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While and after synchronous reset, `busy` is 0, `rdata` is 0x00 and the decoder is in array-read mode.
- R2: In array-read mode, a read strobed at clock edge N returns the stored byte at `addr` on `rdata` after edge N+1. `rdata` holds its value when no read result is due.
- R3: Writing 0xAA to 0x555, then 0x55 to 0x2AA, then 0x90 to 0x555 enters identification mode. The mode persists across any number of reads at any address.
- R4: In identification mode, the read result depends on the low address byte. 0x00 returns the maker code, 0x01 the device code and 0x03 the continuation code. 0x02 returns 0x01 if the sector in the top SECT_BITS address bits has its PROT_MASK bit set, and 0x00 otherwise. Any other low byte returns 0x00.
- R5: Identification mode is left only by a write of 0xF0 at any address. Every other write leaves it in place.
- R6: Writing 0xAA to 0x555, then 0x55 to 0x2AA, then 0xA0 to 0x555, then data to a target address, raises `busy` after the fourth write. `busy` stays high for exactly PROG_CYCLES clocks.
- R7: When the program completes, the target byte becomes its old value AND the written data.
- R8: While `busy` is high, reads return bit 7 as the complement of bit 7 of the data being programmed, with bits 6..0 at zero. All writes, including 0xF0, are ignored.
- R9: A write of 0xF0 between sequence cycles aborts the sequence. Any write that does not match the expected cycle also returns the decoder to idle, with no array change.
- R10: After a program completes, the decoder is back in array-read mode. A later single write does not program anything until a full four-cycle sequence is given again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write cycle strobe |
| rd_en | input | 1 | Read cycle strobe |
| addr | input | AW | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | Embedded program in progress |

## Verification
The bench aims at the places where a decoder of this kind tends to go wrong:
- A reset or a stray write sent during a program must leave the window length and the final byte untouched. A design that honoured it would end early or leave the byte unprogrammed.
- An abort in the set-up state must leave the array unchanged. A decoder that kept a half-finished sequence alive would program on the next write.
- A second program over already-cleared bits must keep them at zero. An overwrite instead of an AND would show up here.
- Identification reads must cover the protected and unprotected sectors and the unused low addresses. Writes other than 0xF0 are sent in identification mode to catch an early exit.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNLK1,
    ST_UNLK2,
    ST_AUTO,
    ST_PSETUP,
    ST_BUSY
  } seq_state_t;

  typedef enum logic [1:0] {
    RS_NONE,
    RS_ARRAY,
    RS_ID,
    RS_STATUS
  } rsel_t;

  localparam int unsigned CMD_AW = 11;

  localparam logic [CMD_AW-1:0] A_UNLK1 = 11'h555;
  localparam logic [CMD_AW-1:0] A_UNLK2 = 11'h2AA;

  localparam logic [7:0] D_UNLK1 = 8'hAA;
  localparam logic [7:0] D_UNLK2 = 8'h55;
  localparam logic [7:0] D_IDENT = 8'h90;
  localparam logic [7:0] D_PROG  = 8'hA0;
  localparam logic [7:0] D_RESET = 8'hF0;

endpackage

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // erased state: every bit set
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first synchronous read port
  always_ff @(posedge clk) begin
    if (en) q <= mem[raddr];
  end

endmodule

// File: rtl/flash_prog_timer.sv
module flash_prog_timer #(
  parameter int unsigned PROG_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int unsigned CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          act;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      act <= 1'b1;
      cnt <= LOAD;
    end else if (act) begin
      if (cnt == '0) act <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign active = act;
  assign done   = act && (cnt == '0);

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    act |-> (cnt <= LOAD)); // R6

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          tmr_done,
  output seq_state_t    state,
  output logic          start,
  output logic [AW-1:0] paddr,
  output logic [7:0]    pdata
);
  seq_state_t nxt;
  logic [CMD_AW-1:0] a_lo;

  assign a_lo = addr[CMD_AW-1:0];

  always_comb begin
    nxt   = state;
    start = 1'b0;
    case (state)
      ST_BUSY: begin
        if (tmr_done) nxt = ST_IDLE;
      end
      ST_AUTO: begin
        if (wr_en && wdata == D_RESET) nxt = ST_IDLE;
      end
      default: begin
        if (wr_en) begin
          if (wdata == D_RESET) begin
            nxt = ST_IDLE;
          end else begin
            case (state)
              ST_IDLE:
                nxt = (a_lo == A_UNLK1 && wdata == D_UNLK1) ? ST_UNLK1 : ST_IDLE;
              ST_UNLK1:
                nxt = (a_lo == A_UNLK2 && wdata == D_UNLK2) ? ST_UNLK2 : ST_IDLE;
              ST_UNLK2: begin
                if (a_lo == A_UNLK1 && wdata == D_IDENT)     nxt = ST_AUTO;
                else if (a_lo == A_UNLK1 && wdata == D_PROG) nxt = ST_PSETUP;
                else                                         nxt = ST_IDLE;
              end
              ST_PSETUP: begin
                nxt   = ST_BUSY;
                start = 1'b1;
              end
              default: nxt = ST_IDLE;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      paddr <= '0;
      pdata <= '0;
    end else begin
      state <= nxt;
      if (start) begin
        paddr <= addr;
        pdata <= wdata;
      end
    end
  end

  AST_BUSY_IGNORES_WRITES: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BUSY && !tmr_done) |=> (state == ST_BUSY)); // R8

  AST_BUSY_ONLY_FROM_SETUP: assert property (@(posedge clk) disable iff (rst)
    $rose(state == ST_BUSY) |-> $past(state == ST_PSETUP && wr_en)); // R6

  AST_IDENT_EXIT_ONLY_RESET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AUTO && !(wr_en && wdata == D_RESET)) |=> (state == ST_AUTO)); // R5

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW          = 11,
  parameter int unsigned SECT_BITS   = 2,
  parameter int unsigned PROG_CYCLES = 8,
  parameter logic [(1<<SECT_BITS)-1:0] PROT_MASK = 4'b0101,
  parameter logic [7:0]  MFR_CODE    = 8'h37,
  parameter logic [7:0]  DEV_CODE    = 8'h86,
  parameter logic [7:0]  CONT_CODE   = 8'h7F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          busy
);
  seq_state_t    state;
  logic          start, tmr_active, tmr_done;
  logic [AW-1:0] paddr;
  logic [7:0]    pdata;
  logic [7:0]    ram_q;
  logic          ram_en;
  logic [AW-1:0] ram_raddr;
  logic [SECT_BITS-1:0] sect;

  flash_seq_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .tmr_done(tmr_done), .state(state), .start(start),
    .paddr(paddr), .pdata(pdata)
  );

  flash_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(start),
    .active(tmr_active), .done(tmr_done)
  );

  // during the program window the read port fetches the target byte
  assign busy      = (state == ST_BUSY);
  assign ram_en    = rd_en | busy;
  assign ram_raddr = busy ? paddr : addr;

  flash_byte_array #(.AW(AW), .DW(8)) u_mem (
    .clk(clk), .en(ram_en), .raddr(ram_raddr), .q(ram_q),
    .we(tmr_done), .waddr(paddr), .wdata(ram_q & pdata)
  );

  // read pipeline, stage 1: capture what the read must return
  rsel_t      rsel_q;
  logic [7:0] rlo_q;
  logic       rprot_q;
  logic       rdq7_q;
  logic       rpend_q;

  assign sect = addr[AW-1 -: SECT_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q  <= RS_NONE;
      rlo_q   <= '0;
      rprot_q <= 1'b0;
      rdq7_q  <= 1'b0;
      rpend_q <= 1'b0;
    end else begin
      rpend_q <= rd_en;
      if (rd_en) begin
        rlo_q   <= addr[7:0];
        rprot_q <= PROT_MASK[sect];
        rdq7_q  <= ~pdata[7];
        if (busy)                  rsel_q <= RS_STATUS;
        else if (state == ST_AUTO) rsel_q <= RS_ID;
        else                       rsel_q <= RS_ARRAY;
      end
    end
  end

  logic [7:0] id_val;
  always_comb begin
    case (rlo_q)
      8'h00:   id_val = MFR_CODE;
      8'h01:   id_val = DEV_CODE;
      8'h02:   id_val = {7'b0, rprot_q};
      8'h03:   id_val = CONT_CODE;
      default: id_val = 8'h00;
    endcase
  end

  // stage 2: registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rpend_q) begin
      case (rsel_q)
        RS_ARRAY:  rdata <= ram_q;
        RS_ID:     rdata <= id_val;
        RS_STATUS: rdata <= {rdq7_q, 7'b0};
        default:   rdata <= '0;
      endcase
    end
  end

  AST_BUSY_MATCHES_TIMER: assert property (@(posedge clk) disable iff (rst)
    busy == tmr_active); // R6

  AST_PROG_ENDS_IN_READ: assert property (@(posedge clk) disable iff (rst)
    tmr_done |=> (!busy && state == ST_IDLE)); // R10

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam int AW = 11;
  localparam int P  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          busy;

  always #4 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .PROG_CYCLES(P)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  int nchk = 0;
  int nerr = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [7:0] mmem [0:(1<<AW)-1];
  int         mst = 0;       // 0 idle,1 unlk1,2 unlk2,3 ident,4 setup,5 busy
  int         mcnt = 0;
  int         mpa = 0;
  logic [7:0] mpd = '0;
  bit         s1v = 0;
  logic [7:0] s1d = '0;
  logic [7:0] exp_rd = '0;

  function automatic logic [7:0] model_read(int a);
    if (mst == 5) return {~mpd[7], 7'b0};
    if (mst == 3) begin
      int lo = a % 256;
      int sc = a / 512;
      if (lo == 0) return 8'h37;
      if (lo == 1) return 8'h86;
      if (lo == 3) return 8'h7F;
      if (lo == 2) return (sc == 0 || sc == 2) ? 8'h01 : 8'h00;
      return 8'h00;
    end
    return mmem[a];
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit w, bit r, int a, logic [7:0] d);
    int nx;
    wr_en = w; rd_en = r; addr = AW'(a); wdata = d;
    @(posedge clk);
    if (s1v) exp_rd = s1d;
    s1v = r;
    if (r) s1d = model_read(a);
    nx = mst;
    if (mst == 5) begin
      if (mcnt == 1) begin
        mmem[mpa] = mmem[mpa] & mpd;
        nx = 0;
      end else mcnt--;
    end else if (mst == 3) begin
      if (w && d == 8'hF0) nx = 0;
    end else if (w) begin
      if (d == 8'hF0) nx = 0;
      else if (mst == 0) nx = (a == 'h555 && d == 8'hAA) ? 1 : 0;
      else if (mst == 1) nx = (a == 'h2AA && d == 8'h55) ? 2 : 0;
      else if (mst == 2) nx = (a == 'h555 && d == 8'h90) ? 3 :
                              (a == 'h555 && d == 8'hA0) ? 4 : 0;
      else if (mst == 4) begin
        mpa = a; mpd = d; mcnt = P; nx = 5;
      end
    end
    mst = nx;
    @(negedge clk);
    check({cur_req, " busy"}, {7'b0, busy}, {7'b0, (mst == 5)});
    check({cur_req, " rdata"}, rdata, exp_rd);
  endtask

  task automatic wr(int a, logic [7:0] d); step(1, 0, a, d); endtask
  task automatic rd(int a); step(0, 1, a, 8'h00); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00); endtask
  task automatic unlock(); wr('h555, 8'hAA); wr('h2AA, 8'h55); endtask

  task automatic expect_read(int a, logic [7:0] exp, string tag);
    rd(a); idle(1);
    check(tag, rdata, exp);
  endtask

  task automatic program_byte(int a, logic [7:0] d);
    unlock(); wr('h555, 8'hA0); wr(a, d);
    idle(P + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mmem[i] = 8'hFF;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 busy in reset", {7'b0, busy}, 8'h00);
    check("R1 rdata in reset", rdata, 8'h00);
    rst = 1'b0;
    cur_req = "R1";
    idle(2);
    check("R1 rdata after reset", rdata, 8'h00);

    // R2: erased array reads and hold
    cur_req = "R2";
    expect_read('h123, 8'hFF, "R2 erased byte");
    idle(3);
    check("R2 rdata held", rdata, 8'hFF);

    // R6 R7 R8: program with disturbances in the window
    cur_req = "R6";
    unlock(); wr('h555, 8'hA0); wr('h123, 8'h5A);
    check("R6 busy after fourth write", {7'b0, busy}, 8'h01);
    cur_req = "R8";
    rd('h123); idle(1);
    check("R8 status dq7 complement", rdata, 8'h80);
    wr('h000, 8'hF0);
    wr('h555, 8'hAA);
    check("R8 busy survives reset write", {7'b0, busy}, 8'h01);
    idle(P);
    check("R6 busy cleared", {7'b0, busy}, 8'h00);
    cur_req = "R7";
    expect_read('h123, 8'h5A, "R7 first program");
    program_byte('h123, 8'hF3);
    expect_read('h123, 8'h52, "R7 AND of old and new");
    program_byte('h124, 8'h80);
    expect_read('h124, 8'h80, "R7 other byte");

    // R10: no latched address after completion
    cur_req = "R10";
    wr('h123, 8'h00);
    idle(P);
    expect_read('h123, 8'h52, "R10 lone write ignored");

    // R3 R4: identification mode
    cur_req = "R3";
    unlock(); wr('h555, 8'h90);
    cur_req = "R4";
    expect_read('h000, 8'h37, "R4 maker code");
    expect_read('h701, 8'h86, "R4 device code");
    expect_read('h103, 8'h7F, "R4 continuation code");
    expect_read('h002, 8'h01, "R4 sector 0 protected");
    expect_read('h202, 8'h00, "R4 sector 1 open");
    expect_read('h402, 8'h01, "R4 sector 2 protected");
    expect_read('h602, 8'h00, "R4 sector 3 open");
    expect_read('h005, 8'h00, "R4 unused low byte");
    cur_req = "R3";
    rd('h7FF); rd('h7FF); rd('h000); idle(1);
    check("R3 mode persists", rdata, 8'h37);

    // R5: only 0xF0 leaves identification mode
    cur_req = "R5";
    wr('h555, 8'hAA); wr('h2AA, 8'h55); wr('h555, 8'hA0); wr('h123, 8'h00);
    expect_read('h001, 8'h86, "R5 other writes ignored");
    wr('h3C7, 8'hF0);
    expect_read('h123, 8'h52, "R5 back to array");

    // R9: aborts and mismatches
    cur_req = "R9";
    unlock(); wr('h100, 8'hF0); wr('h100, 8'h00);
    expect_read('h100, 8'hFF, "R9 abort after unlock");
    unlock(); wr('h555, 8'hA0); wr('h100, 8'hF0); wr('h100, 8'h00);
    idle(P);
    expect_read('h100, 8'hFF, "R9 abort in setup");
    wr('h555, 8'hAA); wr('h555, 8'hAA); wr('h2AA, 8'h55); wr('h555, 8'hA0); wr('h100, 8'h00);
    idle(P);
    expect_read('h100, 8'hFF, "R9 mismatch returns idle");
    unlock(); wr('h554, 8'h90);
    expect_read('h000, 8'hFF, "R9 wrong command address");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule